// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block produces a single output pulse whose length is a programmed number of clock cycles. It works as a synchronous, clocked version of a retriggerable monostable: a down-counter takes the place of a resistor-capacitor timing network. The pulse can start in three ways. The first is a rising edge on the active-high gate while the active-low gate is low. The second is a falling edge on the active-low gate while the active-high gate is high. The third is releasing the active-low clear while both gates are already enabled.

All three control inputs are asynchronous. Each one passes through a synchronizer and then a persistence filter. A level change only counts after it has held steady for a set number of cycles, so a slow or bouncing edge produces exactly one trigger. A trigger during a pulse reloads the counter, so the pulse ends one full duration after the latest trigger. A low clear cuts the pulse short and blocks triggers. Two instances side by side form a dual-channel part.

Top module: `retrig_oneshot`

## Requirements
- R1: A rising edge on `gate_hi_i` while `gate_lo_n_i` is low starts a pulse. `pulse_o` goes high LAT = SYNC_STAGES + FILT_LEN + 1 cycles after the input change and stays high for exactly `duration_i` cycles.
- R2: A falling edge on `gate_lo_n_i` while `gate_hi_i` is high starts a pulse with the same latency and length as in R1.
- R3: A rising edge on `clear_n_i` while `gate_lo_n_i` is low and `gate_hi_i` is high starts a pulse with the same latency and length as in R1.
- R4: A valid trigger during a pulse reloads the counter. The pulse then ends `duration_i` cycles after the reload, with no low gap in between.
- R5: `duration_i` (an unsigned count of clock cycles) is sampled only when a trigger loads the counter. Changing it in the middle of a pulse does not change that pulse.
- R6: While the filtered clear is low, the counter is held at zero, so `pulse_o` is low LAT cycles after `clear_n_i` falls. Any trigger condition met while the clear is low is ignored.
- R7: `pulse_n_o` is always the inverse of `pulse_o`.
- R8: During and after reset, `pulse_o` is low and `pulse_n_o` is high. Input levels that are already present when reset is released produce no pulse.
- R9: A change on a control input that lasts fewer than FILT_LEN cycles is ignored. A bouncing edge produces one trigger, timed from its last stable change.
- R10: A trigger with `duration_i` equal to zero produces no pulse, and it does not shorten a pulse that is already running.
- R11: A rising edge on `gate_hi_i` while `gate_lo_n_i` is high, or a falling edge on `gate_lo_n_i` while `gate_hi_i` is low, does not start a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gate_lo_n_i | input | 1 | Asynchronous active-low gate/trigger input |
| gate_hi_i | input | 1 | Asynchronous active-high gate/trigger input |
| clear_n_i | input | 1 | Asynchronous active-low clear; its release can also trigger |
| duration_i | input | DUR_W | Pulse length in clock cycles, sampled at each trigger |
| pulse_o | output | 1 | Pulse output, high while a pulse is active |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Every result of the block is due a fixed number of cycles after the input change that caused it. A trigger or a clear shows on the outputs LAT cycles later (six with the default parameters), and the pulse falls `duration_i` cycles after that. The bench counts rising clock edges. For each input it drives, it computes the cycle at which each output value is due and queues that value as an expectation. It then compares the outputs at the falling edge of exactly that cycle, and it also checks the cycles just before each edge, so a result that comes one cycle early or late fails.

// File: rtl/retrig_oneshot_pkg.sv
// Package: types and constants shared by the one-shot pulse generator.
// Assumes: the three control inputs are packed in this order everywhere.
package retrig_oneshot_pkg;

    // Number of asynchronous control inputs that are conditioned.
    localparam int NUM_CTL = 3;

    // Filtered levels of the control inputs, packed MSB first.
    typedef struct packed {
        logic gate_lo_n;
        logic gate_hi;
        logic clear_n;
    } ctl_lvl_t;

    // Safe reset levels: both gates disabled, clear asserted.
    localparam logic [NUM_CTL-1:0] CTL_RST = 3'b100;

endpackage

// File: rtl/os_input_cond.sv
// Module: os_input_cond
// Conditions one asynchronous control input. A chain of SYNC_STAGES flops
// synchronizes it. A persistence filter then accepts a new level only after
// it has held for FILT_LEN consecutive cycles.
// Assumes: SYNC_STAGES >= 2 and FILT_LEN >= 1. While track is high, the
// filter follows the synchronized value directly (used during warm-up).
module os_input_cond #(
    parameter int   SYNC_STAGES = 2,
    parameter int   FILT_LEN    = 3,
    parameter logic RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track,
    input  logic raw,
    output logic level
);

    localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] stg;
    logic                   synced;
    logic                   flt;
    logic [CW-1:0]          run_cnt;

    assign synced = stg[SYNC_STAGES-1];
    assign level  = flt;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {SYNC_STAGES{RST_VAL}};
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    // Accept a new level once it has persisted for FILT_LEN cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flt     <= RST_VAL;
            run_cnt <= '0;
        end else if (track) begin
            flt     <= synced;
            run_cnt <= '0;
        end else if (synced == flt) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_LAST) begin
            flt     <= synced;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/os_trig_detect.sv
// Module: os_trig_detect
// Compares the filtered control levels with their previous sample and
// recognises the three trigger conditions. Clear has priority over any
// trigger, and nothing fires until the block is armed.
// Assumes: lvl comes from filtered, glitch-free registers.
module os_trig_detect
    import retrig_oneshot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     armed,
    input  ctl_lvl_t lvl,
    output logic     fire,
    output logic     clear_act
);

    ctl_lvl_t prev;
    logic     hi_rise;
    logic     lo_fall;
    logic     clr_rel;
    logic     gates_on;

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= ctl_lvl_t'(CTL_RST);
        end else begin
            prev <= lvl;
        end
    end

    // Decode the trigger conditions and the clear priority.
    always_comb begin
        gates_on  = !lvl.gate_lo_n && lvl.gate_hi;
        hi_rise   = lvl.gate_hi && !prev.gate_hi && !lvl.gate_lo_n;
        lo_fall   = !lvl.gate_lo_n && prev.gate_lo_n && lvl.gate_hi;
        clr_rel   = lvl.clear_n && !prev.clear_n && gates_on;
        clear_act = !lvl.clear_n;
        fire      = armed && !clear_act && (hi_rise || lo_fall || clr_rel);
    end

endmodule

// File: rtl/os_pulse_timer.sv
// Module: os_pulse_timer
// Down-counter that times the pulse. A load with a non-zero duration
// (re)starts the full count, clear forces zero, and otherwise the count
// falls by one each cycle until it reaches zero.
// Assumes: load and clear are never both high (clear wins if they are).
module os_pulse_timer #(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [DUR_W-1:0] dur,
    output logic [DUR_W-1:0] count,
    output logic             active
);

    // Count down the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (load && (dur != '0)) begin
            count <= dur;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    // The pulse is active while any count remains.
    assign active = (count != '0);

endmodule

// File: rtl/retrig_oneshot.sv
// Module: retrig_oneshot
// One channel of a retriggerable gated one-shot. It conditions the three
// asynchronous controls, detects the trigger conditions, and drives
// complementary outputs from a down-counter. A warm-up window after reset
// lets the filters settle to the pin levels before any edge is accepted.
// Assumes: duration_i is a synchronous input in the clk domain.
module retrig_oneshot
    import retrig_oneshot_pkg::*;
#(
    parameter int DUR_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_lo_n_i,
    input  logic             gate_hi_i,
    input  logic             clear_n_i,
    input  logic [DUR_W-1:0] duration_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    localparam int WARM = SYNC_STAGES + 2;
    localparam int WW   = $clog2(WARM + 1);
    localparam logic [WW-1:0] WARM_END = WW'(WARM);

    logic [NUM_CTL-1:0] raw_vec;
    logic [NUM_CTL-1:0] lvl_vec;
    ctl_lvl_t           lvl;
    logic [WW-1:0]      wcnt;
    logic               armed;
    logic               fire;
    logic               clear_act;
    logic [DUR_W-1:0]   count;
    logic               active;

    assign raw_vec = {gate_lo_n_i, gate_hi_i, clear_n_i};
    assign lvl     = ctl_lvl_t'(lvl_vec);
    assign armed   = (wcnt == WARM_END);

    // Count the warm-up cycles after reset, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (!armed) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // One conditioner per control input.
    for (genvar gi = 0; gi < NUM_CTL; gi++) begin : g_cond
        os_input_cond #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN),
            .RST_VAL     (CTL_RST[gi])
        ) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .track (!armed),
            .raw   (raw_vec[gi]),
            .level (lvl_vec[gi])
        );
    end

    os_trig_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .lvl       (lvl),
        .fire      (fire),
        .clear_act (clear_act)
    );

    os_pulse_timer #(
        .DUR_W (DUR_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fire),
        .clear  (clear_act),
        .dur    (duration_i),
        .count  (count),
        .active (active)
    );

    assign pulse_o   = active;
    assign pulse_n_o = !active;

endmodule

// File: rtl/retrig_oneshot_chk.sv
// Module: retrig_oneshot_chk
// Checker for retrig_oneshot, attached by bind. It relates the trigger
// decode, the clear priority and the countdown across cycles.
module retrig_oneshot_chk #(
    parameter int DUR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             armed,
    input logic             fire,
    input logic             clear_act,
    input logic [DUR_W-1:0] dur,
    input logic [DUR_W-1:0] count,
    input logic             pulse
);

    // R6: a trigger is never accepted while the clear is active.
    a_r6_clear_blocks_fire: assert property (@(posedge clk) disable iff (!rst_n)
        clear_act |-> !fire);

    // R6: an active clear leaves the output low on the next cycle.
    a_r6_clear_drops_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clear_act |=> !pulse);

    // R8: nothing fires before the warm-up window has ended.
    a_r8_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !fire);

    // R4: a trigger with a non-zero duration reloads the full count.
    a_r4_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dur != '0) |=> (count == $past(dur)));

    // R1: without a trigger or a clear, a running count drops by one.
    a_r1_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clear_act && count != '0) |=> (count == $past(count) - 1'b1));

    // R10: a zero-duration trigger on an idle counter starts nothing.
    a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dur == '0 && count == '0) |=> !pulse);

    // R10: a zero-duration trigger does not cut a running count.
    a_r10_zero_running: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dur == '0 && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

bind retrig_oneshot retrig_oneshot_chk #(
    .DUR_W (DUR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .fire      (fire),
    .clear_act (clear_act),
    .dur       (duration_i),
    .count     (count),
    .pulse     (pulse_o)
);

// File: tb/retrig_oneshot_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue the expected output value for
// each cycle that matters, and a monitor compares them at falling edges.
module retrig_oneshot_bench;

    localparam int DUR_W       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int FILT_LEN    = 3;
    localparam int LAT         = SYNC_STAGES + FILT_LEN + 1;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lo_n = 1'b0;
    logic             hi = 1'b1;
    logic             clr_n = 1'b1;
    logic [DUR_W-1:0] dur = '0;
    logic             pulse;
    logic             pulse_n;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    item_t sb[$];

    retrig_oneshot #(
        .DUR_W       (DUR_W),
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_LEN    (FILT_LEN)
    ) u_retrig_oneshot (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_lo_n_i (lo_n),
        .gate_hi_i   (hi),
        .clear_n_i   (clr_n),
        .duration_i  (dur),
        .pulse_o     (pulse),
        .pulse_n_o   (pulse_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int t, logic v, string tag);
        sb.push_back('{t, v, tag});
    endtask

    task automatic expect_pulse(int start, int len, string tag);
        expect_at(start - 1, 1'b0, tag);
        expect_at(start, 1'b1, tag);
        expect_at(start + len - 1, 1'b1, tag);
        expect_at(start + len, 1'b0, tag);
    endtask

    task automatic expect_quiet(int from, int upto, string tag);
        for (int t = from; t <= upto; t += 3) expect_at(t, 1'b0, tag);
    endtask

    task automatic goto(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic go_idle();
        hi = 1'b0;
        lo_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Monitor: compare each queued expectation at its due cycle.
    always @(negedge clk) begin
        item_t it;
        if (rst_n) begin
            while (sb.size() != 0 && sb[0].cyc <= cyc) begin
                it = sb.pop_front();
                checks++;
                if (it.cyc < cyc) begin
                    fails++;
                    $display("FAIL %s: check for cycle %0d missed, actual cycle=%0d expected cycle=%0d",
                             it.tag, it.cyc, cyc, it.cyc);
                end else if (pulse !== it.val) begin
                    fails++;
                    $display("FAIL %s: cycle %0d pulse_o actual=%b expected=%b",
                             it.tag, cyc, pulse, it.val);
                end
                checks++;
                if (pulse_n !== ~it.val) begin
                    fails++;
                    $display("FAIL R7: cycle %0d pulse_n_o actual=%b expected=%b",
                             cyc, pulse_n, ~it.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run state actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int c;
        // R8: outputs idle in reset; levels present at release give no pulse.
        repeat (3) @(negedge clk);
        checks++;
        if (pulse !== 1'b0 || pulse_n !== 1'b1) begin
            fails++;
            $display("FAIL R8: in reset pulse_o/pulse_n_o actual=%b%b expected=01", pulse, pulse_n);
        end
        rst_n = 1'b1;
        c = cyc;
        expect_quiet(c + 1, c + 30, "R8");
        drain();
        go_idle();

        // R11 then R1: gate_lo_n falls with gate_hi low, then gate_hi rises.
        c = cyc;
        lo_n = 1'b0;
        expect_quiet(c + 1, c + 15, "R11");
        goto(c + 16);
        c = cyc;
        dur = 8'd5;
        expect_pulse(c + LAT, 5, "R1");
        hi = 1'b1;
        drain();
        go_idle();

        // R11 then R2: gate_hi rises with gate_lo_n high, then gate_lo_n falls.
        c = cyc;
        hi = 1'b1;
        expect_quiet(c + 1, c + 15, "R11");
        goto(c + 16);
        c = cyc;
        dur = 8'd7;
        expect_pulse(c + LAT, 7, "R2");
        lo_n = 1'b0;
        drain();
        go_idle();

        // R6: triggers during clear are ignored; R3: clear release triggers.
        clr_n = 1'b0;
        repeat (10) @(negedge clk);
        c = cyc;
        dur = 8'd9;
        lo_n = 1'b0;
        hi = 1'b1;
        expect_quiet(c + 1, c + 20, "R6");
        goto(c + 21);
        c = cyc;
        dur = 8'd4;
        expect_pulse(c + LAT, 4, "R3");
        clr_n = 1'b1;
        drain();
        go_idle();

        // R4 retrigger extends the pulse; R5 mid-pulse duration change has no effect.
        lo_n = 1'b0;
        repeat (10) @(negedge clk);
        c = cyc;
        dur = 8'd10;
        expect_at(c + 5, 1'b0, "R4");
        expect_at(c + 6, 1'b1, "R4");
        expect_at(c + 15, 1'b1, "R4");
        expect_at(c + 16, 1'b1, "R4");
        expect_at(c + 22, 1'b1, "R5");
        expect_at(c + 27, 1'b1, "R5");
        expect_at(c + 28, 1'b0, "R4");
        hi = 1'b1;
        goto(c + 6);
        hi = 1'b0;
        goto(c + 10);
        dur = 8'd12;
        hi = 1'b1;
        goto(c + 20);
        dur = 8'd3;
        drain();
        go_idle();

        // R6: clear cuts a running pulse; release with gate_hi low is quiet.
        lo_n = 1'b0;
        repeat (10) @(negedge clk);
        c = cyc;
        dur = 8'd20;
        expect_at(c + 6, 1'b1, "R6");
        expect_at(c + 15, 1'b1, "R6");
        expect_at(c + 16, 1'b0, "R6");
        expect_at(c + 25, 1'b0, "R6");
        expect_at(c + 40, 1'b0, "R6");
        expect_at(c + 46, 1'b0, "R6");
        hi = 1'b1;
        goto(c + 10);
        clr_n = 1'b0;
        goto(c + 25);
        hi = 1'b0;
        goto(c + 33);
        clr_n = 1'b1;
        drain();
        go_idle();

        // R10: a zero-duration trigger starts nothing and cuts nothing.
        lo_n = 1'b0;
        repeat (10) @(negedge clk);
        c = cyc;
        dur = 8'd0;
        expect_quiet(c + 1, c + 20, "R10");
        hi = 1'b1;
        goto(c + 10);
        hi = 1'b0;
        goto(c + 21);
        c = cyc;
        dur = 8'd15;
        expect_at(c + 6, 1'b1, "R10");
        expect_at(c + 20, 1'b1, "R10");
        expect_at(c + 21, 1'b0, "R10");
        expect_at(c + 25, 1'b0, "R10");
        hi = 1'b1;
        goto(c + 7);
        hi = 1'b0;
        goto(c + 11);
        dur = 8'd0;
        hi = 1'b1;
        drain();
        go_idle();

        // R9: a short glitch is ignored; a bouncing edge triggers once.
        lo_n = 1'b0;
        repeat (10) @(negedge clk);
        c = cyc;
        dur = 8'd6;
        expect_quiet(c + 1, c + 15, "R9");
        hi = 1'b1;
        goto(c + 2);
        hi = 1'b0;
        goto(c + 16);
        c = cyc;
        expect_at(c + 7, 1'b0, "R9");
        expect_at(c + 8, 1'b1, "R9");
        expect_at(c + 13, 1'b1, "R9");
        expect_at(c + 14, 1'b0, "R9");
        hi = 1'b1;
        goto(c + 1);
        hi = 1'b0;
        goto(c + 2);
        hi = 1'b1;
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule